// File: doc/BRIEF.md
# Configuration Register Target on a Two-Wire Serial Bus

This block is a target on a two-wire serial bus in the I2C style. It never drives the clock line. It drives the data line only by pulling it low. A system clock much faster than the bus clock oversamples both lines. Two-flop synchronisers feed an edge and START/STOP detector, and a bit-level state machine moves bytes between the bus and a small register file. The file holds sixteen entries. Identification and status bytes come from parameters and status inputs. Two configuration registers drive output pins, and a per-bit write mask keeps their status bits read-only.

The 7-bit target address is `0111` followed by three strap pins, so it lies in the range 0x38 to 0x3F. The strap pins are captured at the first START seen on the bus after reset. That START may begin a transfer to any device. After it, the address stays fixed until the next reset. In a write transfer, the first byte after the address sets the register pointer and each later byte is written at the pointer. A read returns bytes starting at the pointer. Both directions advance the pointer after each data byte.

Top module: `i2c_cfg_target`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal {0111, latched strap}. For any other address it leaves SDA released for the acknowledge bit and for the rest of that transfer.
- R2: The strap pins are sampled at the first START after reset. Later changes to the pins do not alter the address the block answers to.
- R3: SCL is an input only. `sda_oe_o` high means pull SDA low. `sda_oe_o` changes only while the synchronised SCL is low.
- R4: In a write transfer, the first byte after the address loads the 8-bit register pointer. Each later byte is written at the pointer, and the pointer then advances by one.
- R5: A read transfer returns the byte at the current pointer MSB first and advances the pointer by one per byte, wrapping from 0xFF to 0x00. A master NACK ends the read with SDA released.
- R6: Registers 0x00–0x07 are read-only: 0x00/0x01 vendor ID low/high, 0x02/0x03 device ID low/high, 0x04 revision, 0x05 zero, 0x06/0x07 `freq_i` low/high byte.
- R7: Register 0x08 is fully writable, resets to 0x00 and drives `cfg_ctrl_o`.
- R8: Register 0x09 reads as {`lowv_i`, mode[2:0], tsel, `sense_i`, 2'b00}. Writes change only bits 6:3. Bits 6:4 drive `cfg_mode_o` and bit 3 drives `cfg_tsel_o`. Both reset to zero.
- R9: Writes to 0x00–0x07 and 0x0A–0xFF change nothing. Reads of 0x0A–0xFF return 0x00.
- R10: A STOP at any bit returns the block to idle with SDA released and discards a partial byte. A repeated START begins a new address phase.
- R11: The block acknowledges every complete byte written after its own address, including the pointer byte and bytes aimed at read-only or absent registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND value) |
| sda_oe_o | output | 1 | High pulls SDA low, low releases it |
| addr_sel_i | input | 3 | Strap pins forming the low address bits |
| freq_i | input | 16 | Measured frequency status, read at 0x06/0x07 |
| lowv_i | input | 1 | Status bit read at 0x09 bit 7 |
| sense_i | input | 1 | Status bit read at 0x09 bit 2 |
| cfg_ctrl_o | output | 8 | Contents of register 0x08 |
| cfg_mode_o | output | 3 | Register 0x09 bits 6:4 |
| cfg_tsel_o | output | 1 | Register 0x09 bit 3 |

## Verification
The bench sweeps all 128 seven-bit addresses. A decoder that compared the wrong bits, or that drove SDA on a foreign address, would acknowledge more than one of them. It then changes the strap pins and addresses the old and new values. A design that kept sampling the pins would move to the new address. Sixteen write and readback patterns on register 0x09 with varied status inputs expose a missing write mask, which would corrupt the status bits or the unused bits. Bursts over the read-only registers, the empty range and the 0xFF wrap, together with a transfer cut short by a STOP, catch writes that leak into the configuration outputs, a wrong pointer advance, and a block that fails to release the line after a NACK.

// File: rtl/i2c_cfg_pkg.sv
// Shared constants, state encoding and write-mask helper for the
// configuration register target. Assumes an 8-bit register pointer.
package i2c_cfg_pkg;

    localparam int          SEL_W    = 3;
    localparam int          DATA_W   = 8;
    localparam int          PTR_W    = 8;
    localparam logic [3:0]  ADDR_HI  = 4'b0111;
    localparam int          RW_BASE  = 8;
    localparam int          NUM_RW   = 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_END,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_END,
        ST_WR_ACK,
        ST_RD,
        ST_RD_END,
        ST_RD_ACK,
        ST_RD_NEXT
    } tgt_state_t;

    // Writable bits of each writable register, indexed from RW_BASE.
    function automatic logic [DATA_W-1:0] rw_mask(input int idx);
        case (idx)
            0:       return 8'hFF;
            1:       return 8'h78;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
// Synchronises SCL and SDA into the system clock domain and flags SCL
// edges and START/STOP conditions. Assumes the bus is idle-high and
// that each SCL phase lasts several system clocks.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_p;
    logic              sda_p;

    // Shift both lines through the synchroniser chains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
        end
    end

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    // Keep the previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    // Edge and bus-condition decode.
    always_comb begin
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        start_det = scl_s & scl_p & sda_p & ~sda_s;
        stop_det  = scl_s & scl_p & ~sda_p & sda_s;
    end

endmodule

// File: rtl/i2c_target_fsm.sv
// Bit-level target engine: receives the address, decodes it against the
// strap value frozen at the first START, handles pointer/data writes and
// auto-incrementing reads. Samples SDA on SCL rise and changes its own
// SDA drive only after an SCL fall.
module i2c_target_fsm
    import i2c_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [SEL_W-1:0]  addr_sel_i,
    input  logic [DATA_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [PTR_W-1:0]  rd_ptr,
    output logic [SEL_W-1:0]  sel_lat,
    output logic              sel_locked
);

    tgt_state_t        state;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] txreg;
    logic [PTR_W-1:0]  ptr;
    logic [2:0]        cnt;
    logic              rw;
    logic              ptr_phase;

    assign rd_ptr = ptr;

    // Strap capture: freeze the select pins at the first START.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_lat    <= '0;
            sel_locked <= 1'b0;
        end else if (start_det && !sel_locked) begin
            sel_lat    <= addr_sel_i;
            sel_locked <= 1'b1;
        end
    end

    // Protocol sequencing, shifting, pointer handling and SDA drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            shreg     <= '0;
            txreg     <= '0;
            ptr       <= '0;
            cnt       <= '0;
            rw        <= 1'b0;
            ptr_phase <= 1'b0;
            sda_oe    <= 1'b0;
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg <= {shreg[DATA_W-2:0], sda_s};
                            cnt   <= cnt + 3'd1;
                            if (cnt == 3'd7) state <= ST_ADDR_END;
                        end
                    end
                    ST_ADDR_END: begin
                        if (scl_fall) begin
                            if (shreg[7:1] == {ADDR_HI, sel_lat}) begin
                                sda_oe <= 1'b1;
                                rw     <= shreg[0];
                                state  <= ST_ADDR_ACK;
                            end else begin
                                state  <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (rw) begin
                                txreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                                state  <= ST_RD;
                            end else begin
                                sda_oe    <= 1'b0;
                                ptr_phase <= 1'b1;
                                state     <= ST_WR;
                            end
                        end
                    end
                    ST_WR: begin
                        if (scl_rise) begin
                            shreg <= {shreg[DATA_W-2:0], sda_s};
                            cnt   <= cnt + 3'd1;
                            if (cnt == 3'd7) state <= ST_WR_END;
                        end
                    end
                    ST_WR_END: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b1;
                            state  <= ST_WR_ACK;
                            if (ptr_phase) begin
                                ptr       <= shreg;
                                ptr_phase <= 1'b0;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= shreg;
                                ptr     <= ptr + 1'b1;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            state  <= ST_WR;
                        end
                    end
                    ST_RD: begin
                        if (scl_rise) begin
                            cnt <= cnt + 3'd1;
                            if (cnt == 3'd7) state <= ST_RD_END;
                        end else if (scl_fall) begin
                            txreg  <= {txreg[DATA_W-2:0], 1'b0};
                            sda_oe <= ~txreg[DATA_W-2];
                        end
                    end
                    ST_RD_END: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            ptr    <= ptr + 1'b1;
                            state  <= ST_RD_ACK;
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) state <= sda_s ? ST_IDLE : ST_RD_NEXT;
                    end
                    ST_RD_NEXT: begin
                        if (scl_fall) begin
                            txreg  <= rd_data;
                            sda_oe <= ~rd_data[7];
                            cnt    <= '0;
                            state  <= ST_RD;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_cfg_regfile.sv
// Sixteen-entry register file: read-only identity/status bytes and
// NUM_RW writable registers whose bits are gated by per-register masks.
// Addresses outside the map read as zero and ignore writes.
module i2c_cfg_regfile
    import i2c_cfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'h1A2B,
    parameter logic [15:0] DEVICE_ID = 16'h0C3F,
    parameter logic [7:0]  REV_ID    = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [15:0]       freq_i,
    input  logic              lowv_i,
    input  logic              sense_i,
    output logic [7:0]        cfg_ctrl_o,
    output logic [2:0]        cfg_mode_o,
    output logic              cfg_tsel_o
);

    logic [NUM_RW-1:0][DATA_W-1:0] rw_vec;

    for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
        localparam logic [DATA_W-1:0] MASK = rw_mask(g);
        localparam logic [PTR_W-1:0]  ADDR = PTR_W'(RW_BASE + g);
        logic [DATA_W-1:0] q;

        // Masked update of one writable register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && wr_addr == ADDR)
                q <= (q & ~MASK) | (wr_data & MASK);
        end

        assign rw_vec[g] = q;
    end

    assign cfg_ctrl_o = rw_vec[0];
    assign cfg_mode_o = rw_vec[1][6:4];
    assign cfg_tsel_o = rw_vec[1][3];

    // Read multiplexer over the register map.
    always_comb begin
        case (rd_addr)
            8'h00:   rd_data = VENDOR_ID[7:0];
            8'h01:   rd_data = VENDOR_ID[15:8];
            8'h02:   rd_data = DEVICE_ID[7:0];
            8'h03:   rd_data = DEVICE_ID[15:8];
            8'h04:   rd_data = REV_ID;
            8'h06:   rd_data = freq_i[7:0];
            8'h07:   rd_data = freq_i[15:8];
            8'h08:   rd_data = rw_vec[0];
            8'h09:   rd_data = rw_vec[1] | {lowv_i, 4'b0000, sense_i, 2'b00};
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/i2c_cfg_target.sv
// Top of the configuration register target: line synchroniser, target
// engine and register file. The caller builds the open-drain pad from
// sda_oe_o and feeds the resolved line level back on sda_i.
module i2c_cfg_target
    import i2c_cfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID   = 16'h1A2B,
    parameter logic [15:0] DEVICE_ID   = 16'h0C3F,
    parameter logic [7:0]  REV_ID      = 8'h02,
    parameter int          SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe_o,
    input  logic [2:0]  addr_sel_i,
    input  logic [15:0] freq_i,
    input  logic        lowv_i,
    input  logic        sense_i,
    output logic [7:0]  cfg_ctrl_o,
    output logic [2:0]  cfg_mode_o,
    output logic        cfg_tsel_o
);

    logic              scl_s;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              wr_en;
    logic [PTR_W-1:0]  wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [PTR_W-1:0]  rd_ptr;
    logic [DATA_W-1:0] rd_data;
    logic [SEL_W-1:0]  sel_lat;
    logic              sel_locked;

    i2c_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_target_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .addr_sel_i (addr_sel_i),
        .rd_data    (rd_data),
        .sda_oe     (sda_oe_o),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_ptr     (rd_ptr),
        .sel_lat    (sel_lat),
        .sel_locked (sel_locked)
    );

    i2c_cfg_regfile #(
        .VENDOR_ID (VENDOR_ID),
        .DEVICE_ID (DEVICE_ID),
        .REV_ID    (REV_ID)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_ptr),
        .rd_data    (rd_data),
        .freq_i     (freq_i),
        .lowv_i     (lowv_i),
        .sense_i    (sense_i),
        .cfg_ctrl_o (cfg_ctrl_o),
        .cfg_mode_o (cfg_mode_o),
        .cfg_tsel_o (cfg_tsel_o)
    );

endmodule

// File: rtl/i2c_cfg_target_chk.sv
// Protocol and register checker for i2c_cfg_target, attached by bind.
// Observes the strap latch, the SDA drive timing and the write path.
module i2c_cfg_target_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       stop_det,
    input logic       sda_oe_o,
    input logic [2:0] addr_sel_i,
    input logic [2:0] sel_lat,
    input logic       sel_locked,
    input logic       wr_en,
    input logic [7:0] wr_addr,
    input logic [7:0] wr_data,
    input logic [7:0] cfg_ctrl_o,
    input logic [2:0] cfg_mode_o,
    input logic       cfg_tsel_o
);

    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        sel_locked |=> sel_locked && $stable(sel_lat)); // R2

    AST_SEL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_locked) |-> sel_lat == $past(addr_sel_i)); // R2

    AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_s); // R3

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe_o); // R10

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 8'h08) |=> cfg_ctrl_o == $past(wr_data)); // R7

    AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 8'h09) |=>
            (cfg_mode_o == $past(wr_data[6:4])) && (cfg_tsel_o == $past(wr_data[3]))); // R8

    AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != 8'h08 && wr_addr != 8'h09) |=>
            $stable(cfg_ctrl_o) && $stable(cfg_mode_o) && $stable(cfg_tsel_o)); // R9

endmodule

bind i2c_cfg_target i2c_cfg_target_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .stop_det   (stop_det),
    .sda_oe_o   (sda_oe_o),
    .addr_sel_i (addr_sel_i),
    .sel_lat    (sel_lat),
    .sel_locked (sel_locked),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .cfg_ctrl_o (cfg_ctrl_o),
    .cfg_mode_o (cfg_mode_o),
    .cfg_tsel_o (cfg_tsel_o)
);

// File: tb/i2c_cfg_target_bench.sv
// Self-checking bench: bit-banged bus master, register model computed
// from the requirements, address sweep and register pattern sweeps.
module i2c_cfg_target_bench;

    localparam int          CLK_PERIOD = 10;
    localparam int          Q          = 6;
    localparam int          WD_CYCLES  = 190000;
    localparam logic [15:0] VID        = 16'h1A2B;
    localparam logic [15:0] DID        = 16'h0C3F;
    localparam logic [7:0]  REV        = 8'h02;
    localparam logic [6:0]  DEV        = 7'h3D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda_low = 1'b0;
    logic        sda_bus;
    logic        sda_oe_o;
    logic [2:0]  addr_sel = 3'd5;
    logic [15:0] freq = 16'hBEEF;
    logic        lowv = 1'b0;
    logic        sense = 1'b0;
    logic [7:0]  cfg_ctrl_o;
    logic [2:0]  cfg_mode_o;
    logic        cfg_tsel_o;

    int          n_chk = 0;
    int          n_err = 0;
    logic        done = 1'b0;

    logic [7:0]  m_ctrl = 8'h00;
    logic [2:0]  m_mode = 3'd0;
    logic        m_tsel = 1'b0;
    logic [7:0]  b_ptr = 8'h00;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign sda_bus = ~(m_sda_low | sda_oe_o);

    i2c_cfg_target #(
        .VENDOR_ID (VID),
        .DEVICE_ID (DID),
        .REV_ID    (REV)
    ) u_i2c_cfg_target (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_bus),
        .sda_oe_o   (sda_oe_o),
        .addr_sel_i (addr_sel),
        .freq_i     (freq),
        .lowv_i     (lowv),
        .sense_i    (sense),
        .cfg_ctrl_o (cfg_ctrl_o),
        .cfg_mode_o (cfg_mode_o),
        .cfg_tsel_o (cfg_tsel_o)
    );

    function automatic logic [7:0] exp_reg(input logic [7:0] a);
        case (a)
            8'h00:   return VID[7:0];
            8'h01:   return VID[15:8];
            8'h02:   return DID[7:0];
            8'h03:   return DID[15:8];
            8'h04:   return REV;
            8'h06:   return freq[7:0];
            8'h07:   return freq[15:8];
            8'h08:   return m_ctrl;
            8'h09:   return {lowv, m_mode, m_tsel, sense, 2'b00};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; tick(Q);
        m_scl = 1'b1;     tick(Q);
        m_sda_low = 1'b1; tick(Q);
        m_scl = 1'b0;     tick(Q);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; tick(Q);
        m_scl = 1'b1;     tick(Q);
        m_sda_low = 1'b0; tick(2 * Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda_low = ~b; tick(Q);
        m_scl = 1'b1;   tick(2 * Q);
        m_scl = 1'b0;   tick(Q);
    endtask

    task automatic get_bit(output logic b);
        m_sda_low = 1'b0; tick(Q);
        m_scl = 1'b1;     tick(Q);
        b = sda_bus;      tick(Q);
        m_scl = 1'b0;     tick(Q);
    endtask

    task automatic write_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        send_bit(~give_ack);
    endtask

    // START, own address with write, pointer byte.
    task automatic open_write(input logic [7:0] ptr);
        logic ack;
        bus_start();
        write_byte({DEV, 1'b0}, ack);
        chk("R1 own address ack", ack, 1);
        write_byte(ptr, ack);
        chk("R11 pointer byte ack", ack, 1);
        b_ptr = ptr;
    endtask

    // One data byte; updates the model per R4/R7/R8/R9.
    task automatic send_data(input logic [7:0] v);
        logic ack;
        write_byte(v, ack);
        chk("R11 data byte ack", ack, 1);
        if (b_ptr == 8'h08) m_ctrl = v;
        if (b_ptr == 8'h09) begin
            m_mode = v[6:4];
            m_tsel = v[3];
        end
        b_ptr = b_ptr + 8'd1;
    endtask

    // Read n bytes from the current pointer, NACK on the last.
    task automatic read_cur(input int n, input string tag);
        logic       ack;
        logic [7:0] d;
        write_byte({DEV, 1'b1}, ack);
        chk("R1 read address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            read_byte(i < n - 1, d);
            chk(tag, d, exp_reg(b_ptr));
            b_ptr = b_ptr + 8'd1;
        end
        chk("R5 SDA released after NACK", sda_oe_o, 0);
        bus_stop();
    endtask

    // Set pointer, repeated START, then read.
    task automatic read_at(input logic [7:0] ptr, input int n, input string tag);
        open_write(ptr);
        bus_start();
        read_cur(n, tag);
    endtask

    task automatic check_outputs(input string tag);
        chk({tag, " ctrl"}, cfg_ctrl_o, m_ctrl);
        chk({tag, " mode"}, cfg_mode_o, m_mode);
        chk({tag, " tsel"}, cfg_tsel_o, m_tsel);
    endtask

    initial begin : watchdog
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin : stimulus
        logic ack;
        tick(10);
        rst_n = 1'b1;
        tick(5);

        // Reset state (R3, R7, R8).
        chk("R3 SDA released at reset", sda_oe_o, 0);
        check_outputs("R7 R8 reset");

        // R1: sweep all 7-bit addresses with strap 5 (first START latches it).
        for (int a = 0; a < 128; a++) begin
            bus_start();
            write_byte({7'(a), 1'b0}, ack);
            chk("R1 address decode", ack, (7'(a) == DEV) ? 1 : 0);
            bus_stop();
            chk("R1 SDA idle after transfer", sda_oe_o, 0);
        end

        // R2: strap change after the first START is ignored.
        addr_sel = 3'd2;
        tick(4);
        bus_start();
        write_byte({DEV, 1'b0}, ack);
        chk("R2 latched address still acks", ack, 1);
        bus_stop();
        bus_start();
        write_byte({7'h3A, 1'b0}, ack);
        chk("R2 new strap address ignored", ack, 0);
        bus_stop();

        // R7: single write to the control register.
        open_write(8'h08);
        send_data(8'hA5);
        bus_stop();
        check_outputs("R7 single write");

        // R4: burst across 0x08 and 0x09 with auto-increment.
        open_write(8'h08);
        send_data(8'h3C);
        send_data(8'hFF);
        bus_stop();
        check_outputs("R4 burst write");

        // R5: read from current pointer (0x0A after the burst) then wrap test.
        bus_start();
        read_cur(2, "R9 read past map");

        // R8: sweep writes and readbacks of the mixed register.
        for (int v = 0; v < 16; v++) begin
            logic [7:0] val;
            val   = {4'(v), ~4'(v)};
            lowv  = v[0];
            sense = v[1];
            open_write(8'h09);
            send_data(val);
            bus_stop();
            check_outputs("R8 mode sweep");
            read_at(8'h09, 1, "R8 readback");
        end

        // R9/R11: writes into read-only and absent registers.
        open_write(8'h00);
        for (int i = 0; i < 8; i++) send_data(8'hFF);
        bus_stop();
        open_write(8'h0A);
        for (int i = 0; i < 6; i++) send_data(8'hFF);
        bus_stop();
        check_outputs("R9 ignored writes");

        // R6/R9/R5: read the whole map in one burst.
        freq = 16'h4C7D;
        read_at(8'h00, 16, "R6 R9 map burst read");

        // R5: pointer wrap from 0xFF to 0x00, and zeros above the map.
        read_at(8'h0E, 4, "R9 zero region");
        read_at(8'hFF, 2, "R5 pointer wrap");

        // R10: STOP in the middle of a data byte discards it.
        open_write(8'h08);
        send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b1);
        send_bit(1'b0);
        bus_stop();
        chk("R10 SDA released after STOP", sda_oe_o, 0);
        check_outputs("R10 partial byte dropped");
        read_at(8'h08, 1, "R10 recovery read");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule